// File: doc/BRIEF.md
# Cache Line Burst Beat Sequencer

This block runs one cache-line burst of 32 bytes over a 64-bit data bus as four double-word beats. An upstream requester gives it a byte address, a direction, an access kind and the two page attributes (write-through and caching-inhibited). The block registers the burst address and the two transfer indicators when it accepts the request. It then steps a double-word index once for each data acknowledge from the bus. It flags the fourth beat and pulses a completion strobe before it returns to idle.

Reads return the critical double word first and wrap around the line. Writes always start at double word zero. On reads the write-through indicator changes meaning: it separates instruction fetches from data reads. A request whose byte address is not aligned to a double word would spill past the line within one address tenure. The block refuses such a request and reports the refusal with a one-cycle reject pulse.

Top module: `lineBurstSeq`

## Requirements
- R1: A request is accepted only when `reqReady` is high (idle) and `reqValid` is high. `reqReady` is low from the cycle after acceptance until the completion cycle. `reqValid` has no effect on the address, the indicators or the beat index while a burst runs.
- R2: For a read, the first beat index equals request address bits [4:3], where bit 0 is the least significant bit of the byte address. Each later beat adds one modulo 4, so a start of 2 gives the order 2,3,0,1.
- R3: For a write, the beat order is always 0,1,2,3, whatever the value of request address bits [4:3].
- R4: During a burst, `busAddr` holds request bits [31:5]. For a read, bits [4:3] hold the start double word; for a write they are zero. Bits [2:0] are always zero. `busWrite` holds the request direction (1 = write).
- R5: The beat index advances only on a clock edge at which `dataAck` is high. With `dataAck` low it holds.
- R6: `lastBeat` is high exactly while the fourth beat waits for its acknowledge. After that acknowledge, `burstDone` is high for one cycle, `reqReady` is high again in that same cycle, and `burstDone` is low in the cycle after.
- R7: On a read, `busWt` is 0 for kind 1 (instruction fetch) and 1 for every other kind.
- R8: On a write, `busWt` follows `reqAttrWt`. Kind 2 (cache-block flush or store) and kind 3 (snoop push-out) force it to 1. Kind 5 (external control out) forces it to 0.
- R9: `busCi` follows `reqAttrCi`, and kind 4 (external control in) or kind 5 (external control out) forces it to 1, in either direction. Kind 0 is an ordinary load or store.
- R10: A request presented in idle with byte address bits [2:0] not zero is not accepted. `reqReject` is high for one cycle in the next cycle, `reqReady` stays high, and no burst starts.
- R11: `busAddr`, `busWrite`, `busWt` and `busCi` stay constant from the cycle after acceptance to the end of the burst, through stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Burst request present |
| reqAddr | input | 32 | Byte address of the requested double word |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqKind | input | 3 | Access kind: 0 plain, 1 fetch, 2 flush/store, 3 snoop push, 4 ext in, 5 ext out |
| reqAttrWt | input | 1 | Page write-through attribute |
| reqAttrCi | input | 1 | Page caching-inhibited attribute |
| dataAck | input | 1 | Bus accepts the current beat |
| reqReady | output | 1 | Idle, a request may be accepted |
| reqReject | output | 1 | One-cycle pulse: misaligned request refused |
| busAddr | output | 32 | Registered burst address |
| busWrite | output | 1 | Registered burst direction |
| busWt | output | 1 | Registered write-through indicator |
| busCi | output | 1 | Registered cache-inhibit indicator |
| beatIdx | output | 2 | Double-word index of the current beat |
| lastBeat | output | 1 | Current beat is the fourth |
| burstDone | output | 1 | One-cycle pulse after the final acknowledge |

## Verification
The hardest case to reach is a request that arrives in the middle of a stalled burst. Here a new `reqValid` and a held-off acknowledge coincide, and the registered address, indicators and beat index must all ignore the new request. The bench does this in a directed test. It starts a read burst and acknowledges one beat. It then holds `dataAck` low while it presents a different write request with different attributes, and checks every registered output before it lets the burst finish. It also stalls one beat inside each table burst, to show that the wrapping index holds across a wait.

// File: rtl/burstPkg.sv
package burstPkg;

  typedef enum logic [2:0] {
    KIND_PLAIN = 3'd0,
    KIND_FETCH = 3'd1,
    KIND_FLUSH = 3'd2,
    KIND_PUSH  = 3'd3,
    KIND_XIN   = 3'd4,
    KIND_XOUT  = 3'd5
  } accessKind_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;     // request accepted this cycle
    logic advance;  // current beat acknowledged
    logic finish;   // final beat acknowledged
  } seqStrobes_t;

endpackage

// File: rtl/burstAttrEnc.sv
module burstAttrEnc
  import burstPkg::*;
(
  input  logic        isWrite,
  input  accessKind_e kind,
  input  logic        attrWt,
  input  logic        attrCi,
  output logic        wtOut,
  output logic        ciOut
);

  logic extCtl;

  always_comb begin
    extCtl = (kind == KIND_XIN) || (kind == KIND_XOUT);
    ciOut  = attrCi || extCtl;
    if (!isWrite) begin
      // read: indicator separates fetch from data read
      wtOut = (kind != KIND_FETCH);
    end else begin
      unique case (kind)
        KIND_XOUT:             wtOut = 1'b0;
        KIND_FLUSH, KIND_PUSH: wtOut = 1'b1;
        default:               wtOut = attrWt;
      endcase
    end
  end

endmodule

// File: rtl/burstCtl.sv
module burstCtl
  import burstPkg::*;
#(
  parameter int BEATS = 4,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqAligned,
  input  logic             dataAck,
  output logic             reqReady,
  output logic             reqReject,
  output logic             lastBeat,
  output logic             burstDone,
  output logic [CNT_W-1:0] beatCnt,
  output seqStrobes_t      strobes
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BEATS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} seqState_e;

  seqState_e stateQ;
  logic      doneQ;
  logic      rejectQ;
  logic      badReq;
  logic      running;

  always_comb begin
    running         = (stateQ == ST_RUN);
    strobes.load    = !running && reqValid && reqAligned;
    badReq          = !running && reqValid && !reqAligned;
    strobes.advance = running && dataAck;
    strobes.finish  = strobes.advance && (beatCnt == LAST_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      beatCnt <= '0;
      doneQ   <= 1'b0;
      rejectQ <= 1'b0;
    end else begin
      doneQ   <= strobes.finish;
      rejectQ <= badReq;
      if (strobes.load) begin
        stateQ  <= ST_RUN;
        beatCnt <= '0;
      end else if (strobes.finish) begin
        stateQ  <= ST_IDLE;
        beatCnt <= '0;
      end else if (strobes.advance) begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  assign reqReady  = !running;
  assign lastBeat  = running && (beatCnt == LAST_CNT);
  assign burstDone = doneQ;
  assign reqReject = rejectQ;

  // R1: a burst only starts from an accepted request
  p_start_needs_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(reqValid && reqReady));

  // R5: no acknowledge, no movement
  p_hold_without_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    running && !dataAck |=> running && $stable(beatCnt));

  // R6: final acknowledge leads to completion and idle
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat && dataAck |=> burstDone && reqReady);

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone);

  // R10: a refusal never starts a burst
  p_reject_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |-> reqReady && !lastBeat);

endmodule

// File: rtl/burstPath.sv
module burstPath
  import burstPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEATS      = 4,
  parameter int BEAT_BYTES = 8,
  localparam int CNT_W     = $clog2(BEATS),
  localparam int OFF_W     = $clog2(BEAT_BYTES),
  localparam int LINE_LSB  = OFF_W + CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [CNT_W-1:0]  beatCnt,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  accessKind_e       reqKind,
  input  logic              reqAttrWt,
  input  logic              reqAttrCi,
  output logic              reqAligned,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic              busWt,
  output logic              busCi,
  output logic [CNT_W-1:0]  beatIdx
);

  logic [ADDR_W-LINE_LSB-1:0] lineQ;
  logic [CNT_W-1:0]           startQ;
  logic [CNT_W-1:0]           startNext;
  logic                       wtNext;
  logic                       ciNext;

  burstAttrEnc uAttr (
    .isWrite (reqWrite),
    .kind    (reqKind),
    .attrWt  (reqAttrWt),
    .attrCi  (reqAttrCi),
    .wtOut   (wtNext),
    .ciOut   (ciNext)
  );

  always_comb begin
    reqAligned = (reqAddr[OFF_W-1:0] == '0);
    startNext  = reqWrite ? '0 : reqAddr[LINE_LSB-1:OFF_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineQ    <= '0;
      startQ   <= '0;
      busWrite <= 1'b0;
      busWt    <= 1'b0;
      busCi    <= 1'b0;
    end else if (strobes.load) begin
      lineQ    <= reqAddr[ADDR_W-1:LINE_LSB];
      startQ   <= startNext;
      busWrite <= reqWrite;
      busWt    <= wtNext;
      busCi    <= ciNext;
    end
  end

  // wrap inside the line falls out of the counter width
  assign beatIdx = startQ + beatCnt;
  assign busAddr = {lineQ, startQ, {OFF_W{1'b0}}};

  // R2: read starts at the critical double word
  p_read_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load && !reqWrite |=> beatIdx == $past(reqAddr[LINE_LSB-1:OFF_W]));

  // R2: each accepted beat steps the index by one, wrapping
  p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance && !strobes.finish |=> beatIdx == CNT_W'($past(beatIdx) + 1'b1));

  // R3: writes begin at double word zero
  p_write_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load && reqWrite |=> beatIdx == '0);

  // R7: instruction fetch reads negate write-through
  p_fetch_wt_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load && !reqWrite && reqKind == KIND_FETCH |=> !busWt);

  // R9: external control accesses are always cache-inhibited
  p_extctl_ci_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load && (reqKind == KIND_XIN || reqKind == KIND_XOUT) |=> busCi);

  // R11: registered outputs change only on acceptance
  p_hold_outputs_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(busAddr) && $stable(busWt) && $stable(busCi) && $stable(busWrite));

endmodule

// File: rtl/lineBurstSeq.sv
module lineBurstSeq
  import burstPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEATS      = 4,
  parameter int BEAT_BYTES = 8,
  localparam int CNT_W     = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [2:0]        reqKind,
  input  logic              reqAttrWt,
  input  logic              reqAttrCi,
  input  logic              dataAck,
  output logic              reqReady,
  output logic              reqReject,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic              busWt,
  output logic              busCi,
  output logic [CNT_W-1:0]  beatIdx,
  output logic              lastBeat,
  output logic              burstDone
);

  seqStrobes_t      strobes;
  logic [CNT_W-1:0] beatCnt;
  logic             reqAligned;

  burstCtl #(.BEATS(BEATS)) uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqAligned (reqAligned),
    .dataAck    (dataAck),
    .reqReady   (reqReady),
    .reqReject  (reqReject),
    .lastBeat   (lastBeat),
    .burstDone  (burstDone),
    .beatCnt    (beatCnt),
    .strobes    (strobes)
  );

  burstPath #(.ADDR_W(ADDR_W), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .beatCnt    (beatCnt),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .reqKind    (accessKind_e'(reqKind)),
    .reqAttrWt  (reqAttrWt),
    .reqAttrCi  (reqAttrCi),
    .reqAligned (reqAligned),
    .busAddr    (busAddr),
    .busWrite   (busWrite),
    .busWt      (busWt),
    .busCi      (busCi),
    .beatIdx    (beatIdx)
  );

endmodule

// File: tb/tb_lineBurstSeq.sv
module tb_lineBurstSeq;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  logic        clk;
  logic        rstN;
  logic        reqValid;
  logic [31:0] reqAddr;
  logic        reqWrite;
  logic [2:0]  reqKind;
  logic        reqAttrWt;
  logic        reqAttrCi;
  logic        dataAck;
  logic        reqReady;
  logic        reqReject;
  logic [31:0] busAddr;
  logic        busWrite;
  logic        busWt;
  logic        busCi;
  logic [1:0]  beatIdx;
  logic        lastBeat;
  logic        burstDone;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // {addr[39:8], write[7], kind[6:4], attrWt[3], attrCi[2], expWt[1], expCi[0]}
  localparam logic [39:0] VEC [NVEC] = '{
    {32'h0000_1010, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_2018, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    {32'h0000_3010, 1'b1, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0},
    {32'h0000_4008, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    {32'h0000_5000, 1'b1, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_6018, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    {32'h0000_7008, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 1'b1},
    {32'h0000_8008, 1'b0, 3'd4, 1'b0, 1'b0, 1'b1, 1'b1},
    {32'hABCD_9000, 1'b0, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  lineBurstSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqKind(reqKind), .reqAttrWt(reqAttrWt),
    .reqAttrCi(reqAttrCi), .dataAck(dataAck), .reqReady(reqReady),
    .reqReject(reqReject), .busAddr(busAddr), .busWrite(busWrite),
    .busWt(busWt), .busCi(busCi), .beatIdx(beatIdx), .lastBeat(lastBeat),
    .burstDone(burstDone)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic present(input logic [31:0] addr, input logic wr, input logic [2:0] kind,
                         input logic aWt, input logic aCi);
    reqValid  = 1'b1;
    reqAddr   = addr;
    reqWrite  = wr;
    reqKind   = kind;
    reqAttrWt = aWt;
    reqAttrCi = aCi;
  endtask

  task automatic runBurst(input logic [31:0] addr, input logic wr, input logic [2:0] kind,
                          input logic aWt, input logic aCi, input logic eWt, input logic eCi,
                          input int stallBeat);
    logic [1:0]  start;
    logic [31:0] expAddr;
    start   = wr ? 2'd0 : addr[4:3];
    expAddr = wr ? {addr[31:5], 5'b0} : {addr[31:3], 3'b0};
    @(negedge clk);
    present(addr, wr, kind, aWt, aCi);
    @(negedge clk);
    reqValid = 1'b0;
    check("R1 ready low in burst", 32'(reqReady), 32'd0);
    check("R4 bus address", busAddr, expAddr);
    check("R4 direction", 32'(busWrite), 32'(wr));
    check(wr ? "R8 write-through" : "R7 write-through", 32'(busWt), 32'(eWt));
    check("R9 cache-inhibit", 32'(busCi), 32'(eCi));
    for (int b = 0; b < 4; b++) begin
      check(wr ? "R3 write beat order" : "R2 read beat order", 32'(beatIdx), 32'((start + b) & 3));
      check("R6 last beat flag", 32'(lastBeat), 32'(b == 3));
      if (b == stallBeat) begin
        @(negedge clk);
        check("R5 index held on stall", 32'(beatIdx), 32'((start + b) & 3));
        check("R11 address stable", busAddr, expAddr);
        check("R11 indicators stable", {30'd0, busWt, busCi}, {30'd0, eWt, eCi});
      end
      dataAck = 1'b1;
      @(negedge clk);
      dataAck = 1'b0;
    end
    check("R6 done pulse", 32'(burstDone), 32'd1);
    check("R6 ready on done", 32'(reqReady), 32'd1);
    @(negedge clk);
    check("R6 done single cycle", 32'(burstDone), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    reqValid = 1'b0;
    reqAddr = '0;
    reqWrite = 1'b0;
    reqKind = '0;
    reqAttrWt = 1'b0;
    reqAttrCi = 1'b0;
    dataAck = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state (R1, R6, R10)
    check("R1 ready after reset", 32'(reqReady), 32'd1);
    check("R6 no last beat after reset", 32'(lastBeat), 32'd0);
    check("R6 no done after reset", 32'(burstDone), 32'd0);
    check("R10 no reject after reset", 32'(reqReject), 32'd0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      runBurst(VEC[v][39:8], VEC[v][7], VEC[v][6:4], VEC[v][3], VEC[v][2],
               VEC[v][1], VEC[v][0], v % 4);
    end

    // R10: misaligned request refused
    @(negedge clk);
    present(32'h1234_5004, 1'b0, 3'd0, 1'b0, 1'b0);
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 reject pulse", 32'(reqReject), 32'd1);
    check("R10 stays ready", 32'(reqReady), 32'd1);
    @(negedge clk);
    check("R10 reject single cycle", 32'(reqReject), 32'd0);
    check("R10 no burst started", 32'(reqReady), 32'd1);

    // R1: request during a stalled burst is ignored
    @(negedge clk);
    present(32'h0000_0A08, 1'b0, 3'd1, 1'b0, 1'b0);
    @(negedge clk);
    reqValid = 1'b0;
    dataAck = 1'b1;
    @(negedge clk);
    dataAck = 1'b0;
    present(32'hFFFF_FF00, 1'b1, 3'd5, 1'b1, 1'b1);
    @(negedge clk);
    reqValid = 1'b0;
    check("R1 address unchanged by busy request", busAddr, 32'h0000_0A08);
    check("R1 direction unchanged", 32'(busWrite), 32'd0);
    check("R1 indicators unchanged", {30'd0, busWt, busCi}, 32'd0);
    check("R1 index unchanged", 32'(beatIdx), 32'd2);
    for (int b = 0; b < 3; b++) begin
      dataAck = 1'b1;
      @(negedge clk);
      dataAck = 1'b0;
    end
    check("R6 done after ignored request", 32'(burstDone), 32'd1);
    @(negedge clk);
    check("R1 no hidden acceptance", 32'(reqReady), 32'd1);
    check("R1 address still from first burst", busAddr, 32'h0000_0A08);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule